// File: doc/BRIEF.md
# Traffic-Class Window Mapper

This block gives a traffic class to each upstream memory request that starts on the PCI side of a bridge. Configuration writes program four address windows. Each window has an inclusive base and limit, a traffic class and an enable bit. The request address is compared against every window in parallel. The lowest-numbered valid window that contains the address supplies the class. An address that falls in no valid window gets class 0.

A per-class mask picks virtual channel 1 or 0 for the chosen class. That mask applies only while the second channel is switched on; when it is off, every request goes to channel 0. A registered error flag reports two kinds of misconfiguration. The first is an enabled window whose bounds are unusable. The second is a second channel that is switched on while no usable window sends traffic to it. Results appear one clock after the request strobe.

Top module: `tc_window_mapper`

## Requirements
- R1: After reset all windows are disabled, and rsp_valid, rsp_tc, rsp_vc and cfg_err are all zero.
- R2: An address A hits a valid enabled window when base <= A <= limit, with both bounds included. The response then carries that window's traffic class.
- R3: An address that lies in no valid enabled window returns traffic class 0.
- R4: When two or more valid enabled windows contain the address, the window with the lowest index supplies the class.
- R5: A window whose enable bit is 0 has no effect on the traffic class returned.
- R6: An enabled window is invalid when its limit is not greater than its base, or when bits [1:0] of its base or its limit are not zero. cfg_err is raised for it, and the window is ignored for matching.
- R7: While vc2_en is 0, rsp_vc is 0 for every request.
- R8: While vc2_en is 1, rsp_vc equals bit rsp_tc of vc1_tc_mask, where a 1 selects channel 1.
- R9: While vc2_en is 1, cfg_err is raised if no valid enabled window has a class whose vc1_tc_mask bit is 1.
- R10: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high. The class and channel presented with it belong to that request, and back-to-back requests are accepted every cycle.
- R11: A configuration write happens when cfg_we is high. It targets window cfg_win and field cfg_field, where 0 selects the base, 1 the limit, 2 the class (taken from cfg_wdata[2:0]) and 3 the enable (taken from cfg_wdata[0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request address strobe |
| req_addr | input | 32 | Request memory address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window index for the write |
| cfg_field | input | 2 | Field select: 0 base, 1 limit, 2 class, 3 enable |
| cfg_wdata | input | 32 | Write data |
| vc2_en | input | 1 | Second virtual channel enable |
| vc1_tc_mask | input | 8 | Per-class selection of channel 1 |
| rsp_valid | output | 1 | Result strobe, one cycle after req_valid |
| rsp_tc | output | 3 | Traffic class of the request |
| rsp_vc | output | 1 | Virtual channel of the request |
| cfg_err | output | 1 | Configuration error flag |

## Verification
Some properties are checked by assertions on every cycle: the one-cycle response strobe with no spurious results, the channel-0 fallback while the second channel is off, the channel following the class mask, the error flag following any invalid enabled window, and the reset state. Other behaviour only the bench scenarios can show. These are the values of the returned classes: inclusive bound edges, addresses one byte past a limit, overlapping windows resolved by index, disabled and malformed windows being skipped, and the error raised when the second channel has no usable window that feeds it.

// File: rtl/tcm_pkg.sv
// Package tcm_pkg
// Shared field encoding for the configuration write port of the window mapper.
// Assumes the write port field select is two bits wide.
package tcm_pkg;
    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_CLASS = 2'd2,
        FLD_ENA   = 2'd3
    } cfg_field_e;
endpackage

// File: rtl/tcm_window_regs.sv
// Module tcm_window_regs
// Holds base, limit, class and enable for every window. Writes arrive one at a
// time through a single write port that is addressed by window index and field.
// Assumes NUM_WIN >= 2 and ADDR_W > TC_W.
module tcm_window_regs
    import tcm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TC_W    = 3,
    parameter int NUM_WIN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_WIN)-1:0] cfg_win,
    input  logic [1:0]                 cfg_field,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    output logic [ADDR_W-1:0]          base_q  [NUM_WIN],
    output logic [ADDR_W-1:0]          limit_q [NUM_WIN],
    output logic [TC_W-1:0]            tc_q    [NUM_WIN],
    output logic [NUM_WIN-1:0]         en_q
);
    localparam int IDX_W = $clog2(NUM_WIN);

    cfg_field_e field;
    logic       unused_wdata_hi;

    assign field           = cfg_field_e'(cfg_field);
    assign unused_wdata_hi = ^cfg_wdata[ADDR_W-1:TC_W];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        // Update one window's fields when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
                tc_q[i]    <= '0;
                en_q[i]    <= 1'b0;
            end else if (cfg_we && cfg_win == IDX_W'(i)) begin
                case (field)
                    FLD_BASE:  base_q[i]  <= cfg_wdata;
                    FLD_LIMIT: limit_q[i] <= cfg_wdata;
                    FLD_CLASS: tc_q[i]    <= cfg_wdata[TC_W-1:0];
                    FLD_ENA:   en_q[i]    <= cfg_wdata[0];
                    default:   en_q[i]    <= en_q[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/tcm_window_match.sv
// Module tcm_window_match
// Checks one window. It reports whether the window is usable (enabled and well
// formed), whether it is enabled but malformed, and whether an address lies
// inside its inclusive range. Assumes both bounds are byte addresses.
module tcm_window_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_ok,
    output logic              win_bad,
    output logic              hit
);
    logic well_formed;

    // Classify the window and compare the address against its bounds.
    always_comb begin
        well_formed = (limit > base) && (base[1:0] == 2'b00) && (limit[1:0] == 2'b00);
        win_ok      = en && well_formed;
        win_bad     = en && !well_formed;
        hit         = win_ok && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/tcm_priority_pick.sv
// Module tcm_priority_pick
// Picks the class of the lowest-indexed window that hits, or class 0 when none
// hits. Assumes the hit vector is already gated by window validity.
module tcm_priority_pick #(
    parameter int NUM_WIN = 4,
    parameter int TC_W    = 3
) (
    input  logic [NUM_WIN-1:0] hit,
    input  logic [TC_W-1:0]    tc_in [NUM_WIN],
    output logic [TC_W-1:0]    tc_out
);
    // Scan from the highest index down so the lowest index is written last.
    always_comb begin
        tc_out = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                tc_out = tc_in[i];
            end
        end
    end
endmodule

// File: rtl/tc_window_mapper.sv
// Module tc_window_mapper
// Tags upstream memory requests with a traffic class taken from four address
// windows, then maps the class to virtual channel 0 or 1. Results are
// registered, with one cycle of latency. The error flag is registered from the
// window configuration and the channel settings.
// Assumes vc1_tc_mask has one bit per traffic class.
module tc_window_mapper
    import tcm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TC_W    = 3,
    parameter int NUM_WIN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_WIN)-1:0] cfg_win,
    input  logic [1:0]                 cfg_field,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    input  logic                       vc2_en,
    input  logic [(1<<TC_W)-1:0]       vc1_tc_mask,
    output logic                       rsp_valid,
    output logic [TC_W-1:0]            rsp_tc,
    output logic                       rsp_vc,
    output logic                       cfg_err
);
    logic [ADDR_W-1:0]  win_base  [NUM_WIN];
    logic [ADDR_W-1:0]  win_limit [NUM_WIN];
    logic [TC_W-1:0]    win_tc    [NUM_WIN];
    logic [NUM_WIN-1:0] win_en_vec;
    logic [NUM_WIN-1:0] win_ok_vec;
    logic [NUM_WIN-1:0] win_bad_vec;
    logic [NUM_WIN-1:0] win_hit_vec;
    logic [TC_W-1:0]    sel_tc;
    logic               sel_vc;
    logic               vc1_fed;
    logic               err_d;

    tcm_window_regs #(
        .ADDR_W  (ADDR_W),
        .TC_W    (TC_W),
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .base_q    (win_base),
        .limit_q   (win_limit),
        .tc_q      (win_tc),
        .en_q      (win_en_vec)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        tcm_window_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .base    (win_base[i]),
            .limit   (win_limit[i]),
            .en      (win_en_vec[i]),
            .addr    (req_addr),
            .win_ok  (win_ok_vec[i]),
            .win_bad (win_bad_vec[i]),
            .hit     (win_hit_vec[i])
        );
    end

    tcm_priority_pick #(
        .NUM_WIN (NUM_WIN),
        .TC_W    (TC_W)
    ) u_pick (
        .hit    (win_hit_vec),
        .tc_in  (win_tc),
        .tc_out (sel_tc)
    );

    // Map the chosen class to a channel, with a fallback to channel 0.
    always_comb begin
        sel_vc = vc2_en && vc1_tc_mask[sel_tc];
    end

    // Find whether any usable window feeds channel 1, and form the error term.
    always_comb begin
        vc1_fed = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_ok_vec[i] && vc1_tc_mask[win_tc[i]]) begin
                vc1_fed = 1'b1;
            end
        end
        err_d = (|win_bad_vec) || (vc2_en && !vc1_fed);
    end

    // Register the response; class and channel hold between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tc    <= '0;
            rsp_vc    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_tc <= sel_tc;
                rsp_vc <= sel_vc;
            end
        end
    end

    // Register the configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= err_d;
        end
    end
endmodule

// File: rtl/tcm_checker.sv
// Module tcm_checker
// Assertions for tc_window_mapper. The bind at the end of this file attaches
// the module to every instance of the mapper.
module tcm_checker #(
    parameter int NUM_WIN = 4,
    parameter int TC_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 vc2_en,
    input logic [(1<<TC_W)-1:0] vc1_tc_mask,
    input logic                 rsp_valid,
    input logic [TC_W-1:0]      rsp_tc,
    input logic                 rsp_vc,
    input logic                 cfg_err,
    input logic [NUM_WIN-1:0]   win_en,
    input logic [NUM_WIN-1:0]   win_bad
);
    logic [(1<<TC_W)-1:0] mask_seen;
    logic                 vc2_seen;

    // Keep the channel settings that were present at the last request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_seen <= '0;
            vc2_seen  <= 1'b0;
        end else begin
            mask_seen <= vc1_tc_mask;
            vc2_seen  <= vc2_en;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && rsp_tc == '0 && !rsp_vc && win_en == '0 && !cfg_err)); // R1
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_VC0_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vc2_en) |=> !rsp_vc); // R7
    AST_VC_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_valid)) |-> (rsp_vc == (vc2_seen && mask_seen[rsp_tc]))); // R8
    AST_BAD_WIN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (|win_bad) |=> cfg_err); // R6
endmodule

bind tc_window_mapper tcm_checker #(
    .NUM_WIN (NUM_WIN),
    .TC_W    (TC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vc2_en      (vc2_en),
    .vc1_tc_mask (vc1_tc_mask),
    .rsp_valid   (rsp_valid),
    .rsp_tc      (rsp_tc),
    .rsp_vc      (rsp_vc),
    .cfg_err     (cfg_err),
    .win_en      (win_en_vec),
    .win_bad     (win_bad_vec)
);

// File: tb/tc_window_mapper_tb.sv
// Bench for tc_window_mapper. A driver task queues the expected class and
// channel for each request. A monitor process pops and compares them as
// responses appear.
module tc_window_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        vc2_en = 1'b0;
    logic [7:0]  vc1_tc_mask = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_tc;
    logic        rsp_vc;
    logic        cfg_err;

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  tc;
        logic        vc;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    tc_window_mapper u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .cfg_we      (cfg_we),
        .cfg_win     (cfg_win),
        .cfg_field   (cfg_field),
        .cfg_wdata   (cfg_wdata),
        .vc2_en      (vc2_en),
        .vc1_tc_mask (vc1_tc_mask),
        .rsp_valid   (rsp_valid),
        .rsp_tc      (rsp_tc),
        .rsp_vc      (rsp_vc),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [2:0] tc, input logic vc, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        e.addr = a; e.tc = tc; e.vc = vc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input logic [1:0] w, input logic [31:0] b, input logic [31:0] l,
                           input logic [2:0] tc, input logic en);
        wr(w, 2'd0, b);
        wr(w, 2'd1, l);
        wr(w, 2'd2, {29'h1FFF_FFFF, tc});
        wr(w, 2'd3, {31'h0, en});
    endtask

    task automatic check_err(input logic exp, input string tag);
        idle(2);
        check(cfg_err === exp, tag, {31'h0, cfg_err}, {31'h0, exp});
    endtask

    // Monitor: compare every response against the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 response without request", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_tc === e.tc, {e.tag, " class"}, {29'h0, rsp_tc}, {29'h0, e.tc});
                check(rsp_vc === e.vc, {e.tag, " channel"}, {31'h0, rsp_vc}, {31'h0, e.vc});
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_tc === 3'd0 && rsp_vc === 1'b0, "R1 outputs after reset",
              {28'h0, rsp_valid, rsp_tc}, 32'h0);
        check(cfg_err === 1'b0, "R1 error flag after reset", {31'h0, cfg_err}, 32'h0);
        send(32'h0000_1000, 3'd0, 1'b0, "R1 no window enabled");
        idle(2);

        // R11 programming: window 0 covers 0x1000..0x1FFC, window 1 covers 0x1800..0x2FFC.
        vc1_tc_mask = 8'b0010_0000;
        set_win(2'd0, 32'h0000_1000, 32'h0000_1FFC, 3'd5, 1'b1);
        set_win(2'd1, 32'h0000_1800, 32'h0000_2FFC, 3'd3, 1'b1);
        check_err(1'b0, "R6 well formed windows");

        send(32'h0000_1000, 3'd5, 1'b0, "R2 base edge");
        send(32'h0000_1FFC, 3'd5, 1'b0, "R4 limit edge overlap");
        send(32'h0000_2FFC, 3'd3, 1'b0, "R2 window1 limit");
        send(32'h0000_1800, 3'd5, 1'b0, "R4 overlap lowest index");
        send(32'h0000_2FFD, 3'd0, 1'b0, "R3 past limit");
        send(32'h0000_0FFF, 3'd0, 1'b0, "R3 below base");
        send(32'h8000_0000, 3'd0, 1'b0, "R7 miss with channel off");
        idle(3);
        check(sb.size() == 0, "R10 all responses seen", sb.size(), 32'h0);

        vc2_en = 1'b1;
        check_err(1'b0, "R9 channel1 fed by window0");
        send(32'h0000_1000, 3'd5, 1'b1, "R8 class5 to channel1");
        send(32'h0000_2000, 3'd3, 1'b0, "R8 class3 to channel0");
        send(32'h0000_3000, 3'd0, 1'b0, "R8 class0 to channel0");
        idle(2);

        wr(2'd0, 2'd3, 32'h0);
        send(32'h0000_1000, 3'd0, 1'b0, "R5 disabled window ignored");
        send(32'h0000_1800, 3'd3, 1'b0, "R5 next window takes over");
        check_err(1'b1, "R9 no window feeds channel1");
        vc1_tc_mask = 8'b0000_1000;
        check_err(1'b0, "R9 window1 now feeds channel1");
        send(32'h0000_2000, 3'd3, 1'b1, "R8 class3 to channel1");
        idle(2);

        set_win(2'd2, 32'h0000_5000, 32'h0000_4000, 3'd6, 1'b1);
        check_err(1'b1, "R6 limit below base");
        send(32'h0000_4800, 3'd0, 1'b0, "R6 inverted window ignored");
        send(32'h0000_5000, 3'd0, 1'b0, "R6 inverted window base ignored");
        wr(2'd2, 2'd1, 32'h0000_6000);
        check_err(1'b0, "R6 window2 fixed");
        send(32'h0000_5800, 3'd6, 1'b0, "R2 window2 hit");
        wr(2'd2, 2'd0, 32'h0000_5002);
        check_err(1'b1, "R6 unaligned base");
        send(32'h0000_5800, 3'd0, 1'b0, "R6 unaligned window ignored");
        wr(2'd2, 2'd0, 32'h0000_5000);
        wr(2'd2, 2'd1, 32'h0000_6001);
        check_err(1'b1, "R6 unaligned limit");
        wr(2'd2, 2'd1, 32'h0000_5000);
        check_err(1'b1, "R6 limit equal to base");
        wr(2'd2, 2'd3, 32'h0);
        check_err(1'b0, "R6 disabled bad window not flagged");

        vc2_en = 1'b0;
        send(32'h0000_2000, 3'd3, 1'b0, "R7 channel off forces channel0");
        idle(3);
        check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule